// File: doc/BRIEF.md
# CAN Interrupt Register Bank

This block keeps the interrupt state of a CAN controller: a sticky status word, a mask word and a write-one-to-clear acknowledge path. It drives a single registered interrupt request. The protocol engine reports conditions as one-cycle pulses. The transmit-FIFO-full condition is the exception: it arrives as a level, and only its rising edge counts. Software reaches the block through a plain register port. The port has a two-bit address, a write strobe and write data. Read data is combinational from the address.

The control word carries a core-enable bit and a loopback bit. Any write that leaves core-enable at 0 drops a fixed subset of status bits: error, RX OK, TX OK and arbitration lost. All other status bits, including TX FIFO full, are removed only through the acknowledge register. In loopback mode a single TX-OK report from the core becomes two status events: RX OK first, then TX OK one cycle later.

Top module: `can_irq_bank`

## Requirements
- R1: After reset, every register reads 0 at all four addresses and `irq` is 0. The addresses are 0 control, 1 status, 2 mask, 3 acknowledge.
- R2: A pulse on `evt_pulse[k]` sets a status bit that reads back 1 in the cycle after the pulse and stays set. The mapping from pulse index k to status bit is: k=0..8 map to status bits 20..28, in the order wake-up, sleep, bus-off, error, RX not empty, RX overflow, RX underflow, RX OK, TX high-priority buffer full. k=9 maps to bit 30 (TX OK) and k=10 maps to bit 31 (arbitration lost).
- R3: Status bit 29 (TX FIFO full) is set only by a 0-to-1 change of `txf_full`. While `txf_full` stays high, no new set occurs, so writes into a full FIFO cannot raise it again once it has been acknowledged.
- R4: Writing a 1 to a bit in the acknowledge register clears that status bit. Writing a 0 leaves it unchanged. The acknowledge register reads as 0.
- R5: If a set event and an acknowledge of the same bit land in the same cycle, the bit ends up set.
- R6: Any write to the control register with bit 0 (core enable) at 0 clears status bits 23, 27, 30 and 31 and leaves bits 20–22, 24–26, 28 and 29 unchanged. A control write with bit 0 at 1 clears nothing.
- R7: Mask bits 31:20 are read/write. Mask bits 19:0 always read 0.
- R8: `irq` is a register. It goes high one cycle after the status register holds a bit whose mask bit is also 1. It goes low one cycle after no such bit remains.
- R9: With control bit 1 (loopback) set, a TX-OK pulse (k=9) sets status bit 27 in the following cycle and status bit 30 one cycle after that.
- R10: Writes to the status address have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 mask, 3 acknowledge |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 11 | One-cycle condition pulses from the protocol engine |
| txf_full | input | 1 | TX FIFO full level |
| irq | output | 1 | Interrupt request, registered |

## Verification
The hardest cases to reach from the ports involve two agents acting in the same clock cycle. One is a core event that coincides with a software acknowledge of the same bit. The other is a TX-FIFO-full level that stays high across an acknowledge. The stimulus table places the event pulse and the acknowledge write in one cycle, and then holds `txf_full` high through a later acknowledge so that no second rising edge appears. Loopback ordering is checked by reading the status register in each of the two cycles after a single TX-OK pulse.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int unsigned REG_DW  = 32;
  localparam int unsigned REG_AW  = 2;
  localparam int unsigned SRC_LSB = 20;
  localparam int unsigned SRC_N   = REG_DW - SRC_LSB;
  localparam int unsigned EVT_N   = SRC_N - 1;

  // status lane positions (lane i sits at word bit SRC_LSB+i)
  localparam int unsigned IX_ERR  = 3;
  localparam int unsigned IX_RXOK = 7;
  localparam int unsigned IX_TXF  = 9;
  localparam int unsigned IX_TXOK = 10;
  localparam int unsigned IX_ARB  = 11;
  localparam int unsigned EVT_TXOK = IX_TXOK - 1;

  // lanes dropped by a control write with core enable low
  localparam logic [SRC_N-1:0] DIS_CLR_MASK =
    SRC_N'((1 << IX_ERR) | (1 << IX_RXOK) | (1 << IX_TXOK) | (1 << IX_ARB));

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_ACK  = 2'd3
  } reg_sel_e;

  // pulse inputs skip the FIFO-full lane, which comes from an edge detector
  function automatic logic [SRC_N-1:0] spread_events(input logic [EVT_N-1:0] evt,
                                                     input logic txf_rise);
    logic [SRC_N-1:0] v;
    for (int i = 0; i < IX_TXF; i++) v[i] = evt[i];
    v[IX_TXF] = txf_rise;
    for (int i = IX_TXF + 1; i < SRC_N; i++) v[i] = evt[i-1];
    return v;
  endfunction

  function automatic logic [REG_DW-1:0] lane_to_word(input logic [SRC_N-1:0] v);
    return {v, {SRC_LSB{1'b0}}};
  endfunction

  function automatic logic [SRC_N-1:0] word_to_lane(input logic [REG_DW-1:0] w);
    return w[REG_DW-1:SRC_LSB];
  endfunction

endpackage

// File: rtl/can_irq_evt.sv
module can_irq_evt
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_en,
  input  logic [EVT_N-1:0] evt_pulse,
  input  logic             txf_full,
  output logic [SRC_N-1:0] set_vec
);

  logic txf_q;
  logic txf_rise;
  logic lb_tx_dly;
  logic evt_txok;

  assign evt_txok = evt_pulse[EVT_TXOK];
  assign txf_rise = txf_full & ~txf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txf_q     <= 1'b0;
      lb_tx_dly <= 1'b0;
    end else begin
      txf_q     <= txf_full;
      lb_tx_dly <= lb_en & evt_txok;
    end
  end

  always_comb begin
    set_vec = spread_events(evt_pulse, txf_rise);
    if (lb_en) begin
      set_vec[IX_RXOK] = set_vec[IX_RXOK] | evt_txok;
      set_vec[IX_TXOK] = 1'b0;
    end
    set_vec[IX_TXOK] = set_vec[IX_TXOK] | lb_tx_dly;
  end

  // R3: a level held high never yields a second set
  a_r3_no_reset_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(txf_full)) |-> !set_vec[IX_TXF]);

  // R9: loopback report sets RX OK now, TX OK one cycle later
  a_r9_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && evt_txok) |-> set_vec[IX_RXOK]);
  a_r9_tx_next: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_en && evt_txok) |=> set_vec[IX_TXOK]);

endmodule

// File: rtl/can_irq_stat.sv
module can_irq_stat
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_vec,
  input  logic [SRC_N-1:0] clr_vec,
  input  logic             dis_clr,
  output logic [SRC_N-1:0] stat
);

  for (genvar g = 0; g < SRC_N; g++) begin : g_lane
    logic drop;
    if (DIS_CLR_MASK[g]) begin : g_dis
      assign drop = clr_vec[g] | dis_clr;
    end else begin : g_keep
      assign drop = clr_vec[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          stat[g] <= 1'b0;
      else if (set_vec[g]) stat[g] <= 1'b1;
      else if (drop)       stat[g] <= 1'b0;
    end

    // R5: a set always lands, even against an acknowledge
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> stat[g]);
    // R4: an acknowledge without a set clears the lane
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> !stat[g]);
    // R2: no lane rises without its set event
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat[g] && !set_vec[g]) |=> !stat[g]);
    // R2/R6: a set lane holds unless a clearing source acts
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[g] && !clr_vec[g] && !(dis_clr && DIS_CLR_MASK[g])) |=> stat[g]);
    if (DIS_CLR_MASK[g]) begin : g_chk
      // R6: core disable drops this lane
      a_r6_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_clr && !set_vec[g]) |=> !stat[g]);
    end
  end

endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [SRC_N-1:0]  stat,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [SRC_N-1:0]  clr_vec,
  output logic              dis_clr,
  output logic              lb_en,
  output logic              irq
);

  reg_sel_e         sel;
  logic             core_en;
  logic [SRC_N-1:0] mask_q;
  logic             hit_any;
  logic             unused_wbits;

  assign sel          = reg_sel_e'(reg_addr);
  assign unused_wbits = ^reg_wdata[SRC_LSB-1:2];

  assign clr_vec = (reg_wr && sel == SEL_ACK) ? word_to_lane(reg_wdata) : '0;
  assign dis_clr = reg_wr && sel == SEL_CTRL && !reg_wdata[0];
  assign hit_any = |(stat & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_en <= 1'b0;
      lb_en   <= 1'b0;
      mask_q  <= '0;
      irq     <= 1'b0;
    end else begin
      if (reg_wr && sel == SEL_CTRL) begin
        core_en <= reg_wdata[0];
        lb_en   <= reg_wdata[1];
      end
      if (reg_wr && sel == SEL_MASK) mask_q <= word_to_lane(reg_wdata);
      irq <= hit_any;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata = {{(REG_DW-2){1'b0}}, lb_en, core_en};
      SEL_STAT: reg_rdata = lane_to_word(stat);
      SEL_MASK: reg_rdata = lane_to_word(mask_q);
      default:  reg_rdata = '0;
    endcase
  end

  // R8: request follows the masked status with one register of delay
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> irq);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> !irq);
  // R7: reserved mask positions read as zero
  a_r7_mask_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MASK) |-> (reg_rdata[SRC_LSB-1:0] == '0));
  // R4: acknowledge register reads zero
  a_r4_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ACK) |-> (reg_rdata == '0));
  // R6: only a control write with enable low raises the drop strobe
  a_r6_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    dis_clr |-> (reg_wr && reg_addr == 2'd0));

endmodule

// File: rtl/can_irq_bank.sv
module can_irq_bank
  import can_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  input  logic              txf_full,
  output logic              irq
);

  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;
  logic [SRC_N-1:0] stat;
  logic             dis_clr;
  logic             lb_en;

  can_irq_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lb_en     (lb_en),
    .evt_pulse (evt_pulse),
    .txf_full  (txf_full),
    .set_vec   (set_vec)
  );

  can_irq_stat u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .dis_clr (dis_clr),
    .stat    (stat)
  );

  can_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .stat      (stat),
    .reg_rdata (reg_rdata),
    .clr_vec   (clr_vec),
    .dis_clr   (dis_clr),
    .lb_en     (lb_en),
    .irq       (irq)
  );

  // R10: status changes only through set, acknowledge or disable sources
  a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0 && !dis_clr) |=> $stable(stat));

endmodule

// File: tb/can_irq_bank_bench.sv
module can_irq_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] evt_pulse = '0;
  logic        txf_full = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  can_irq_bank u_can_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .txf_full(txf_full), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [10:0] evt;
    logic        txf;
    logic [31:0] ack;
    logic [31:0] exp_stat;
    logic        exp_irq;
  } vec_t;

  // mask = TX OK | arbitration lost during the walk
  localparam vec_t VECS [8] = '{
    '{11'h001, 1'b0, 32'h0000_0000, 32'h0010_0000, 1'b0}, // R2 wake-up
    '{11'h600, 1'b0, 32'h0000_0000, 32'hC010_0000, 1'b1}, // R2 TX OK + arb lost
    '{11'h000, 1'b0, 32'h4000_0000, 32'h8010_0000, 1'b1}, // R4 ack one bit
    '{11'h000, 1'b1, 32'h0000_0000, 32'hA010_0000, 1'b1}, // R3 rising edge
    '{11'h000, 1'b1, 32'hA000_0000, 32'h0010_0000, 1'b0}, // R3 held high, acked
    '{11'h008, 1'b1, 32'h0080_0000, 32'h0090_0000, 1'b0}, // R5 set beats ack
    '{11'h000, 1'b0, 32'h0090_0000, 32'h0000_0000, 1'b0}, // R4 ack two bits
    '{11'h000, 1'b1, 32'h0000_0000, 32'h2000_0000, 1'b0}  // R3 new edge
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] pos_of(input int k);
    // R2 mapping: indices below 9 follow bit 20 upward, the rest skip bit 29
    return (k < 9) ? (32'h1 << (20 + k)) : (32'h1 << (21 + k));
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d, 32'h0, "R1 reset read");
    end
    check({31'b0, irq}, 32'h0, "R1 irq reset");

    // R7 mask reserved bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d);
    check(d, 32'hFFF0_0000, "R7 mask readback");
    wr(2'd2, 32'hC000_0000);

    // table walk
    foreach (VECS[i]) begin
      evt_pulse = VECS[i].evt;
      txf_full  = VECS[i].txf;
      if (VECS[i].ack != 0) begin
        reg_addr = 2'd3; reg_wdata = VECS[i].ack; reg_wr = 1'b1;
      end
      @(negedge clk);
      evt_pulse = '0; reg_wr = 1'b0;
      rd(2'd1, d);
      check(d, VECS[i].exp_stat, "R2/R3/R4/R5 table status");
      @(negedge clk);
      check({31'b0, irq}, {31'b0, VECS[i].exp_irq}, "R8 table irq");
    end

    // R2 per-index mapping
    txf_full = 1'b0;
    wr(2'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 11; k++) begin
      evt_pulse = 11'(1 << k);
      @(negedge clk);
      evt_pulse = '0;
      rd(2'd1, d);
      check(d, pos_of(k), "R2 position");
      wr(2'd3, 32'hFFFF_FFFF);
    end

    // R6 core disable drops a subset
    wr(2'd0, 32'h1);
    evt_pulse = 11'h7FF; txf_full = 1'b1;
    @(negedge clk);
    evt_pulse = '0;
    rd(2'd1, d);
    check(d, 32'hFFF0_0000, "R2 all set");
    wr(2'd0, 32'h0);
    rd(2'd1, d);
    check(d, 32'h3770_0000, "R6 disable clears subset");
    wr(2'd0, 32'h1);
    rd(2'd1, d);
    check(d, 32'h3770_0000, "R6 enable write clears nothing");

    // R10 status write ignored
    wr(2'd1, 32'h0);
    rd(2'd1, d);
    check(d, 32'h3770_0000, "R10 status write");

    // R4 zero ack, ack readback
    wr(2'd3, 32'h0);
    rd(2'd1, d);
    check(d, 32'h3770_0000, "R4 zero ack");
    rd(2'd3, d);
    check(d, 32'h0, "R4 ack reads zero");
    wr(2'd3, 32'h3770_0000);
    rd(2'd1, d);
    check(d, 32'h0, "R4 ack all");

    // R8 request timing
    txf_full = 1'b0;
    wr(2'd2, 32'h0010_0000);
    @(negedge clk);
    evt_pulse = 11'h001;
    @(negedge clk);
    evt_pulse = '0;
    check({31'b0, irq}, 32'h0, "R8 irq one cycle late");
    @(negedge clk);
    check({31'b0, irq}, 32'h1, "R8 irq high");
    wr(2'd3, 32'h0010_0000);
    check({31'b0, irq}, 32'h1, "R8 irq holds during ack");
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R8 irq falls");
    wr(2'd2, 32'h0);
    evt_pulse = 11'h001;
    @(negedge clk);
    evt_pulse = '0;
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R8 masked");
    wr(2'd3, 32'hFFFF_FFFF);

    // R9 loopback ordering
    wr(2'd0, 32'h3);
    evt_pulse = 11'h200;
    @(negedge clk);
    evt_pulse = '0;
    rd(2'd1, d);
    check(d, 32'h0800_0000, "R9 RX OK first");
    @(negedge clk);
    rd(2'd1, d);
    check(d, 32'h4800_0000, "R9 TX OK next");
    rd(2'd0, d);
    check(d, 32'h3, "R9 control readback");

    finish_run();
  end

endmodule